// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Encoder

This block gathers the single-cycle event pulses raised by an I2C controller's bus engine into sticky status flags and gates each flag with a per-event enable bit. Seven events are tracked: arbitration lost, missing acknowledge, register-access ready, receive data ready, transmit data ready, stop condition seen and addressed as a target. When at least one flag is both pending and enabled, a single interrupt request line is raised.

Software services the line by reading a vector register. The vector returns a small code for the most urgent pending and enabled event and clears that event's flag as a side effect. Software repeats the read until the vector returns zero, so several simultaneous events come out one per read in priority order. A status register shows the raw flags, which software can also clear directly with write-one-to-clear writes. It also shows two live bus levels that never interrupt.

The register port is a simple strobe interface. Read data is combinational from the current state. Side effects of a read or a write take place at the clock edge that ends the access cycle.

Top module: `i2c_irq_vec`

## Requirements
- R1: After reset all seven event flags and all enable bits are 0, the vector reads 0 and irq_o is 0.
- R2: A 1 on ev_i[i] for one cycle sets event flag i, and the flag stays set. Bit i of ev_i maps to vector code i+1 in this order: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 addressed as target. The flag shows in status bit i at offset 0x08.
- R3: A write to status (0x08) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. An event pulse in the same cycle as its clear leaves the flag set.
- R4: The enable register at offset 0x04 holds bits 6:0, with bit i enabling event i. Bits above 6 read as 0.
- R5: The vector at offset 0x28 reads the code (i+1) of the lowest-indexed event that is both flagged and enabled. It reads 0 when no such event exists.
- R6: A vector read clears only the flag of the event it reported, so repeated reads report the pending events one by one in ascending code order and then return 0. An event pulse in the same cycle as that read keeps its flag set.
- R7: A flagged event whose enable bit is 0 is skipped by the vector, is not cleared by a vector read, and stays visible in status.
- R8: irq_o is 1 exactly when at least one flag is set together with its enable bit.
- R9: Status bit 12 reads the live bus_busy_i level and bit 11 reads the live rx_shift_full_i level. Writes do not change them and they never raise irq_o.
- R10: Accesses to any other offset read 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | 7 | Event pulses, one bit per event |
| bus_busy_i | input | 1 | Live bus-busy level |
| rx_shift_full_i | input | 1 | Live receive-shift-full level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that a read and a write strobe never occur in the same cycle and that ev_i carries one-cycle pulses. A pulse may, however, coincide with a clear of the same flag. The bench drives every access as a one-cycle strobe with an idle cycle after it, and it drives pulses and coincident clears as deliberate collisions. It walks the vector through a full seven-event drain, a partially enabled mix and the set-wins-over-clear cases for both clear paths. It also toggles the live levels while events are masked.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int unsigned EV_COUNT = 7;

    typedef enum logic [2:0] {
        VEC_NONE     = 3'd0,
        VEC_ARB_LOST = 3'd1,
        VEC_NO_ACK   = 3'd2,
        VEC_ACC_RDY  = 3'd3,
        VEC_RX_RDY   = 3'd4,
        VEC_TX_RDY   = 3'd5,
        VEC_STOP     = 3'd6,
        VEC_AS_TGT   = 3'd7
    } vec_code_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
    parameter int unsigned         ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]   MASK_OFS = 8'h04,
    parameter logic [ADDR_W-1:0]   STAT_OFS = 8'h08,
    parameter logic [ADDR_W-1:0]   VEC_OFS  = 8'h28
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic              sel_mask_o,
    output logic              sel_stat_o,
    output logic              sel_vec_o,
    output logic              mask_we_o,
    output logic              stat_we_o,
    output logic              vec_re_o
);

    always_comb begin
        sel_mask_o = (addr_i == MASK_OFS);
        sel_stat_o = (addr_i == STAT_OFS);
        sel_vec_o  = (addr_i == VEC_OFS);
        mask_we_o  = wr_i & sel_mask_o;
        stat_we_o  = wr_i & sel_stat_o;
        vec_re_o   = rd_i & sel_vec_o;
    end

    // R10
    always_comb begin
        sel_onehot_chk: assert ($onehot0({sel_mask_o, sel_stat_o, sel_vec_o}));
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    typedef struct packed {
        logic [N-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R2
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(flags_o));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned N  = 7,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [CW-1:0] code_o
);

    for (genvar i = 0; i < N; i++) begin : g_grant
        if (i == 0) begin : g_first
            assign grant_o[i] = req_i[i];
        end else begin : g_rest
            assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
        end
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) code_o = code_o | CW'(i + 1);
        end
    end

    // R5
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant_o));
    end

endmodule

// File: rtl/i2c_irq_vec.sv
module i2c_irq_vec
    import i2c_irq_pkg::*;
#(
    parameter int unsigned       N        = EV_COUNT,
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       DATA_W   = 16,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h04,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h08,
    parameter logic [ADDR_W-1:0] VEC_OFS  = 8'h28,
    parameter int unsigned       RSF_BIT  = 11,
    parameter int unsigned       BB_BIT   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      ev_i,
    input  logic              bus_busy_i,
    input  logic              rx_shift_full_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam int unsigned CW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0] mask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic sel_mask, sel_stat, sel_vec;
    logic mask_we, stat_we, vec_re;
    logic [N-1:0]  flags, pend, grant, clr;
    logic [CW-1:0] vec_code;
    logic [DATA_W-1:0] stat_word;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:N];

    irq_reg_decode #(
        .ADDR_W  (ADDR_W),
        .MASK_OFS(MASK_OFS),
        .STAT_OFS(STAT_OFS),
        .VEC_OFS (VEC_OFS)
    ) u_dec (
        .addr_i    (reg_addr_i),
        .wr_i      (reg_wr_i),
        .rd_i      (reg_rd_i),
        .sel_mask_o(sel_mask),
        .sel_stat_o(sel_stat),
        .sel_vec_o (sel_vec),
        .mask_we_o (mask_we),
        .stat_we_o (stat_we),
        .vec_re_o  (vec_re)
    );

    assign pend = flags & ctl_q.mask;

    irq_prio_enc #(.N(N), .CW(CW)) u_enc (
        .req_i  (pend),
        .grant_o(grant),
        .code_o (vec_code)
    );

    always_comb begin
        clr = '0;
        if (stat_we) clr = clr | reg_wdata_i[N-1:0];
        if (vec_re)  clr = clr | grant;
    end

    irq_flag_bank #(.N(N)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_i),
        .clr_i  (clr),
        .flags_o(flags)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (mask_we) ctl_d.mask = reg_wdata_i[N-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        stat_word          = '0;
        stat_word[N-1:0]   = flags;
        stat_word[RSF_BIT] = rx_shift_full_i;
        stat_word[BB_BIT]  = bus_busy_i;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (sel_mask)      reg_rdata_o[N-1:0] = ctl_q.mask;
        else if (sel_stat) reg_rdata_o = stat_word;
        else if (sel_vec)  reg_rdata_o[CW-1:0] = vec_code;
    end

    assign irq_o = |pend;

    // R6
    vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_re && grant != '0) |=> ((flags & $past(grant & ~ev_i)) == '0));

    // R8
    irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_code != '0));

    // R5
    vec_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> (flags[vec_code - 1'b1] && ctl_q.mask[vec_code - 1'b1]));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(ctl_q.mask));

endmodule

// File: tb/i2c_irq_vec_tb.sv
`timescale 1ns/1ps
module i2c_irq_vec_tb;

    localparam logic [7:0] A_MASK = 8'h04;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_VEC  = 8'h28;
    localparam logic [7:0] A_NONE = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev_i = '0;
    logic        bus_busy_i = 1'b0;
    logic        rx_shift_full_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;
    logic        probe = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
        bit          is_irq;
    } item_t;

    item_t sbq[$];

    always #2.5 clk = ~clk;

    i2c_irq_vec u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_i           (ev_i),
        .bus_busy_i     (bus_busy_i),
        .rx_shift_full_i(rx_shift_full_i),
        .reg_wr_i       (reg_wr_i),
        .reg_rd_i       (reg_rd_i),
        .reg_addr_i     (reg_addr_i),
        .reg_wdata_i    (reg_wdata_i),
        .reg_rdata_o    (reg_rdata_o),
        .irq_o          (irq_o)
    );

    // monitor: pops one expected item per sampled access
    always @(negedge clk) begin
        if (rst_n && (reg_rd_i || probe)) begin
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %h expected none", reg_rdata_o);
            end else begin
                item_t it;
                logic [15:0] act;
                it = sbq.pop_front();
                act = it.is_irq ? {15'b0, irq_o} : reg_rdata_o;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic access(input bit wr, input bit rd, input logic [7:0] a,
                          input logic [15:0] d, input logic [6:0] ev,
                          input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = a; reg_wdata_i = d; ev_i = ev;
        if (rd) sbq.push_back('{exp, tag, 1'b0});
        @(posedge clk); #1;
        reg_wr_i = 1'b0; reg_rd_i = 1'b0; ev_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        access(1'b0, 1'b1, a, 16'h0, 7'h0, exp, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        access(1'b1, 1'b0, a, d, 7'h0, 16'h0, "");
    endtask

    task automatic pulse(input logic [6:0] ev);
        access(1'b0, 1'b0, A_NONE, 16'h0, ev, 16'h0, "");
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        @(posedge clk); #1;
        probe = 1'b1;
        sbq.push_back('{{15'b0, exp}, tag, 1'b1});
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, 16'h0000, "R1 status after reset");
        rd(A_MASK, 16'h0000, "R1 mask after reset");
        rd(A_VEC,  16'h0000, "R1 vector after reset");
        chk_irq(1'b0, "R1 irq after reset");

        // R2 flags set, R7 masked events stay
        pulse(7'h21);
        rd(A_STAT, 16'h0021, "R2 flags from pulses");
        chk_irq(1'b0, "R7 masked events no irq");
        rd(A_VEC,  16'h0000, "R7 masked events skipped by vector");
        rd(A_STAT, 16'h0021, "R7 masked flags kept after vector read");

        // R4 mask register
        wr(A_MASK, 16'hFFFF);
        rd(A_MASK, 16'h007F, "R4 mask upper bits read zero");
        chk_irq(1'b1, "R8 irq with enabled pending");

        // R5 / R6 full drain in priority order
        pulse(7'h7F);
        rd(A_STAT, 16'h007F, "R2 all seven flags");
        for (int c = 1; c <= 7; c++) rd(A_VEC, 16'(c), "R5 R6 drain order");
        rd(A_VEC,  16'h0000, "R6 vector zero after drain");
        rd(A_STAT, 16'h0000, "R6 flags cleared by drain");
        chk_irq(1'b0, "R8 irq low after drain");

        // R3 write-one-to-clear
        pulse(7'h7F);
        wr(A_STAT, 16'h0005);
        rd(A_STAT, 16'h007A, "R3 ones clear selected flags");
        wr(A_STAT, 16'h0000);
        rd(A_STAT, 16'h007A, "R3 zeros leave flags");

        // R7 partial enable
        wr(A_MASK, 16'h0010);
        rd(A_VEC,  16'h0005, "R7 only enabled event reported");
        rd(A_VEC,  16'h0000, "R7 masked events not reported");
        rd(A_STAT, 16'h006A, "R7 masked flags untouched");
        chk_irq(1'b0, "R8 irq low with only masked flags");

        // R9 live levels
        @(posedge clk); #1;
        bus_busy_i = 1'b1; rx_shift_full_i = 1'b1;
        rd(A_STAT, 16'h186A, "R9 live levels visible");
        wr(A_STAT, 16'h1800);
        rd(A_STAT, 16'h186A, "R9 live levels not writable");
        chk_irq(1'b0, "R9 live levels never interrupt");
        @(posedge clk); #1;
        bus_busy_i = 1'b0; rx_shift_full_i = 1'b0;
        rd(A_STAT, 16'h006A, "R9 live levels follow inputs");

        // R3 set wins over write clear
        access(1'b1, 1'b0, A_STAT, 16'h0002, 7'h02, 16'h0, "");
        rd(A_STAT, 16'h006A, "R3 event beats clear");

        // R6 set wins over vector clear
        wr(A_MASK, 16'h0002);
        access(1'b0, 1'b1, A_VEC, 16'h0, 7'h02, 16'h0002, "R6 vector read with event");
        rd(A_VEC,  16'h0002, "R6 flag kept by coincident event");
        rd(A_VEC,  16'h0000, "R6 vector zero after clear");
        rd(A_STAT, 16'h0068, "R6 only reported flag cleared");

        // R10 unmapped offset
        wr(A_NONE, 16'hFFFF);
        rd(A_NONE, 16'h0000, "R10 unmapped reads zero");
        rd(A_MASK, 16'h0002, "R10 unmapped write leaves mask");
        rd(A_STAT, 16'h0068, "R10 unmapped write leaves flags");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule